// File: doc/BRIEF.md
# Shared-Line Bus Ownership Handoff

This block decides who drives a local bus: the host processor or one of two alternate bus masters. Each alternate master shares a single active-low line with the block and uses it for the whole exchange. It pulls the line low for one clock to ask for the bus. The block answers with a one-clock low on the same line. The master pulls the line low for one more clock when it is done. The line is modelled as a sampled level (`rg_in`) plus a per-line pull-down enable (`rg_drive`). The board wires these as an open-drain net.

A request is never granted in the middle of a host bus cycle. It waits until `cycle_done` is seen. A request is also held off while `lock_hold` says an indivisible instruction is still running. When the grant is given, `bus_float` tells the host's bus drivers to go to high impedance. `bus_float` stays high until the owning master releases the bus. If both lines are pending at the grant decision, line 0 wins. The losing request is remembered and served as soon as the bus comes back.

Top module: `rg_handoff`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_float` is 0 and `rg_drive` is all zeros.
- R2: A request is a clock edge at which `rg_in[i]` is 0 while `rg_drive[i]` is 0. After a request, no grant appears while `cycle_done` is sampled 0. `bus_float` stays 0 during that wait.
- R3: Suppose a request is pending, and at a clock edge `cycle_done` is 1 and `lock_hold` is 0. Then after that edge `bus_float` becomes 1, and `rg_drive` has exactly the winner's bit at 1 for exactly one clock.
- R4: While `lock_hold` is sampled 1, no grant is issued, even with `cycle_done` at 1.
- R5: When both lines are pending at the grant decision, line 0 (`rg_drive` bit 0) is granted.
- R6: The block's own grant low on the line is never taken as a release. `bus_float` stays 1 while the owner leaves its line high.
- R7: A low on the owner's line sampled at edge k is a release. `bus_float` stays 1 after edge k and drops to 0 after edge k+1.
- R8: A request that loses the grant, or that arrives while another master owns the bus, stays pending. It is granted once the bus has come back to the host and a cycle end is seen.
- R9: At most one bit of `rg_drive` is 1 at any time, and only while `bus_float` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rg_in | input | N_CH | Sampled level of each shared request/grant line (0 = low) |
| rg_drive | output | N_CH | Pull-down enable per line; 1 pulls that line low for the grant |
| cycle_done | input | 1 | 1 when the host's current bus cycle is finishing |
| lock_hold | input | 1 | 1 while an indivisible (locked) instruction is executing |
| bus_float | output | 1 | 1 to put the host's bus drivers in high impedance |

## Verification
Some properties are checked by assertions on every clock:
- the reset state;
- at most one pull-down at a time, and only while the bus is floated;
- the grant lasting a single clock and keeping the float high afterwards;
- a float rise always following a sampled cycle end with no lock;
- a float fall always following a low on a line.

Other behaviours need the bench's scenarios, because they depend on which pending request gets served and when:
- which line wins when both are pending;
- a late line-0 request overtaking a waiting line-1 request;
- a losing request being served after the release;
- the exact length of the wait under `cycle_done` and `lock_hold`.

// File: rtl/rg_handoff_pkg.sv
package rg_handoff_pkg;
   typedef enum logic [2:0] {
      ST_HOST   = 3'd0,
      ST_WAIT   = 3'd1,
      ST_GRANT  = 3'd2,
      ST_MASTER = 3'd3,
      ST_RETURN = 3'd4
   } rg_state_e;
endpackage

// File: rtl/rg_line_sense.sv
module rg_line_sense #(
   parameter int N_CH = 2
) (
   input  logic [N_CH-1:0] line_lvl,
   input  logic [N_CH-1:0] own_pull,
   output logic [N_CH-1:0] ext_low
);
   // A low level only counts as a master's pulse when this block is not pulling the line itself.
   for (genvar g = 0; g < N_CH; g++) begin : g_line
      assign ext_low[g] = ~line_lvl[g] & ~own_pull[g];
   end
endmodule

// File: rtl/rg_prio_pick.sv
module rg_prio_pick #(
   parameter int N_CH = 2,
   localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [N_CH-1:0] req,
   output logic            any,
   output logic [IW-1:0]   idx
);
   // Fixed priority: the lowest index wins.
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/rg_owner_fsm.sv
module rg_owner_fsm
   import rg_handoff_pkg::*;
#(
   parameter int N_CH = 2,
   localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] ext_low,
   input  logic            cycle_done,
   input  logic            lock_hold,
   input  logic            win_any,
   input  logic [IW-1:0]   win_idx,
   output logic [N_CH-1:0] want,
   output rg_state_e       state,
   output logic [IW-1:0]   owner
);
   rg_state_e       state_d;
   logic [IW-1:0]   owner_d;
   logic [N_CH-1:0] pend_q, pend_d;

   // Pending requests plus the ones sampled this cycle; this feeds the priority picker.
   assign want = pend_q | ext_low;

   always_comb begin
      state_d = state;
      owner_d = owner;
      pend_d  = pend_q | ext_low;
      unique case (state)
         ST_HOST:   if (|want) state_d = ST_WAIT;
         ST_WAIT: begin
            if (cycle_done && !lock_hold && win_any) begin
               state_d         = ST_GRANT;
               owner_d         = win_idx;
               pend_d[win_idx] = 1'b0;
            end
         end
         ST_GRANT:  state_d = ST_MASTER;
         ST_MASTER: begin
            // The owner's low is a release, not a new request.
            if (ext_low[owner]) begin
               state_d       = ST_RETURN;
               pend_d[owner] = pend_q[owner];
            end
         end
         ST_RETURN: state_d = ST_HOST;
         default:   state_d = ST_HOST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_HOST;
         owner  <= '0;
         pend_q <= '0;
      end else begin
         state  <= state_d;
         owner  <= owner_d;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/rg_handoff.sv
module rg_handoff
   import rg_handoff_pkg::*;
#(
   parameter int N_CH = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] rg_in,
   output logic [N_CH-1:0] rg_drive,
   input  logic            cycle_done,
   input  logic            lock_hold,
   output logic            bus_float
);
   localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1;

   if (N_CH < 2) begin : g_bad_cfg
      $error("rg_handoff: N_CH must be at least 2");
   end

   logic [N_CH-1:0] ext_low;
   logic [N_CH-1:0] want;
   logic            win_any;
   logic [IW-1:0]   win_idx;
   rg_state_e       state;
   logic [IW-1:0]   owner;

   rg_line_sense #(.N_CH(N_CH)) u_sense (
      .line_lvl (rg_in),
      .own_pull (rg_drive),
      .ext_low  (ext_low)
   );

   rg_prio_pick #(.N_CH(N_CH)) u_pick (
      .req (want),
      .any (win_any),
      .idx (win_idx)
   );

   rg_owner_fsm #(.N_CH(N_CH)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_low    (ext_low),
      .cycle_done (cycle_done),
      .lock_hold  (lock_hold),
      .win_any    (win_any),
      .win_idx    (win_idx),
      .want       (want),
      .state      (state),
      .owner      (owner)
   );

   assign bus_float = (state == ST_GRANT) || (state == ST_MASTER) || (state == ST_RETURN);

   for (genvar g = 0; g < N_CH; g++) begin : g_drive
      assign rg_drive[g] = (state == ST_GRANT) && (owner == IW'(g));
   end
endmodule

// File: rtl/rg_handoff_chk.sv
module rg_handoff_chk #(
   parameter int N_CH = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] rg_in,
   input logic [N_CH-1:0] rg_drive,
   input logic            cycle_done,
   input logic            lock_hold,
   input logic            bus_float
);
   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!bus_float && rg_drive == '0)); // R1
   AST_FLOAT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_float) |-> ($past(cycle_done) && !$past(lock_hold))); // R2
   AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lock_hold) && $rose(bus_float)) |-> 1'b0); // R4
   AST_FLOAT_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_float) |-> (|rg_drive)); // R3
   AST_GRANT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (|rg_drive) |=> (rg_drive == '0)); // R3
   AST_GRANT_NOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (|rg_drive) |=> bus_float); // R6
   AST_RELEASE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_float) |-> ($past(rg_in, 2) != {N_CH{1'b1}})); // R7
   AST_SINGLE_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rg_drive)); // R9
   AST_PULL_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (|rg_drive) |-> bus_float); // R9
endmodule

bind rg_handoff rg_handoff_chk #(.N_CH(N_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rg_in      (rg_in),
   .rg_drive   (rg_drive),
   .cycle_done (cycle_done),
   .lock_hold  (lock_hold),
   .bus_float  (bus_float)
);

// File: tb/rg_handoff_bench.sv
module rg_handoff_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] m_pull = 2'b00;
   logic [1:0] rg_in;
   logic [1:0] rg_drive;
   logic       cycle_done = 1'b0;
   logic       lock_hold = 1'b0;
   logic       bus_float;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // reference model
   int  ph = 0;          // 0 host, 1 waiting, 2 granting, 3 master, 4 returning
   int  own = 0;
   bit  pend [2] = '{0, 0};
   bit  exp_float = 0;
   bit [1:0] exp_drive = 2'b00;

   // wired-AND line: low when the master or the block pulls it
   assign rg_in = ~(m_pull | rg_drive);

   always #(CLK_PERIOD/2) clk = ~clk;

   rg_handoff #(.N_CH(2)) u_rg_handoff (
      .clk        (clk),
      .rst_n      (rst_n),
      .rg_in      (rg_in),
      .rg_drive   (rg_drive),
      .cycle_done (cycle_done),
      .lock_hold  (lock_hold),
      .bus_float  (bus_float)
   );

   task automatic check(input string tag);
      total++;
      if (bus_float !== exp_float) begin
         bad++;
         $display("FAIL %s bus_float actual=%0b expected=%0b t=%0t", tag, bus_float, exp_float, $time);
      end
      total++;
      if (rg_drive !== exp_drive) begin
         bad++;
         $display("FAIL %s rg_drive actual=%b expected=%b t=%0t", tag, rg_drive, exp_drive, $time);
      end
   endtask

   task automatic model_edge(input bit [1:0] pull, input bit done, input bit lk);
      bit seen [2];
      bit [1:0] low;
      low = pull | exp_drive;
      for (int i = 0; i < 2; i++) seen[i] = low[i] && !exp_drive[i];
      case (ph)
         0: begin
            for (int i = 0; i < 2; i++) if (seen[i]) pend[i] = 1;
            if (pend[0] || pend[1]) ph = 1;
         end
         1: begin
            for (int i = 0; i < 2; i++) if (seen[i]) pend[i] = 1;
            if (done && !lk && (pend[0] || pend[1])) begin
               own = pend[0] ? 0 : 1;
               pend[own] = 0;
               ph = 2;
            end
         end
         2: begin
            for (int i = 0; i < 2; i++) if (seen[i]) pend[i] = 1;
            ph = 3;
         end
         3: begin
            for (int i = 0; i < 2; i++) if (seen[i] && i != own) pend[i] = 1;
            if (seen[own]) ph = 4;
         end
         default: begin
            for (int i = 0; i < 2; i++) if (seen[i]) pend[i] = 1;
            ph = 0;
         end
      endcase
      exp_float = (ph >= 2);
      exp_drive = (ph == 2) ? (2'b01 << own) : 2'b00;
   endtask

   // called at a negedge: apply inputs for one cycle, then compare after the edge
   task automatic step(input bit [1:0] pull, input bit done, input bit lk, input string tag);
      m_pull     = pull;
      cycle_done = done;
      lock_hold  = lk;
      model_edge(pull, done, lk);
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   task automatic idle(input int n, input bit done, input string tag);
      for (int k = 0; k < n; k++) step(2'b00, done, 1'b0, tag);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      step(2'b00, 1'b0, 1'b0, "R1 after reset");

      // R2/R3/R6/R7: line 0 request, held until cycle end
      step(2'b01, 1'b0, 1'b0, "R2 request line0");
      idle(3, 1'b0, "R2 waiting for cycle end");
      step(2'b00, 1'b1, 1'b0, "R3 grant line0");
      idle(4, 1'b0, "R6 master owns, no release");
      step(2'b01, 1'b0, 1'b0, "R7 release line0");
      idle(3, 1'b0, "R7 float returns");

      // R4: lock holds the grant off
      step(2'b10, 1'b1, 1'b1, "R4 request line1 locked");
      for (int k = 0; k < 4; k++) step(2'b00, 1'b1, 1'b1, "R4 locked, no grant");
      step(2'b00, 1'b1, 1'b0, "R4 lock off, grant line1");
      idle(2, 1'b0, "R6 line1 owns");
      step(2'b10, 1'b0, 1'b0, "R7 release line1");
      idle(2, 1'b0, "R7 idle");

      // R5/R8: simultaneous requests
      step(2'b11, 1'b0, 1'b0, "R5 both request");
      step(2'b00, 1'b1, 1'b0, "R5 line0 wins");
      idle(3, 1'b0, "R8 line1 pending while line0 owns");
      step(2'b01, 1'b0, 1'b0, "R8 line0 release");
      idle(2, 1'b0, "R8 back to host then wait");
      step(2'b00, 1'b1, 1'b0, "R8 line1 served");
      idle(2, 1'b0, "R8 line1 owns");
      step(2'b10, 1'b0, 1'b0, "R7 line1 release");
      idle(2, 1'b0, "R7 idle");

      // R5: a late line-0 request overtakes a waiting line-1 request
      step(2'b10, 1'b0, 1'b0, "R5 line1 waits");
      step(2'b01, 1'b0, 1'b0, "R5 line0 arrives");
      step(2'b00, 1'b1, 1'b0, "R5 line0 overtakes");
      idle(2, 1'b0, "R6 line0 owns");

      // R8: request arriving during ownership
      step(2'b10, 1'b0, 1'b0, "R8 line1 asks during ownership");
      idle(2, 1'b1, "R8 no preemption");
      step(2'b01, 1'b1, 1'b0, "R8 line0 release");
      step(2'b00, 1'b1, 1'b0, "R8 return");
      step(2'b00, 1'b1, 1'b0, "R8 host to wait");
      step(2'b00, 1'b1, 1'b0, "R9 grant line1");
      idle(2, 1'b0, "R9 line1 owns");
      step(2'b10, 1'b0, 1'b0, "R7 release line1");
      idle(3, 1'b1, "R2 no requests, no grant");

      // R1: reset in the middle of ownership
      step(2'b01, 1'b1, 1'b0, "R2 request line0");
      step(2'b00, 1'b1, 1'b0, "R3 grant line0");
      rst_n = 1'b0;
      ph = 0; own = 0; pend = '{0, 0}; exp_float = 0; exp_drive = 2'b00;
      @(negedge clk);
      check("R1 reset mid ownership");
      rst_n = 1'b1;
      idle(2, 1'b1, "R1 idle after reset");

      finish_run();
   end
endmodule